// File: doc/BRIEF.md
# Error-Tolerant Approximate Adder

This block adds two unsigned operands and accepts a small, bounded error in the result. In exchange, the carry chain that would otherwise run the full width is cut short. Each operand is split into two parts at a parameterised position. The high-order part is summed exactly by a ripple-carry chain with a carry-in of zero. The low-order part is summed with no carry at all.

The low-order sum is built in two steps. A control chain finds the most significant low bit where both operands are 1. From that bit down, it asserts a per-bit force-to-one signal. A row of modified XOR cells then outputs the plain XOR of the operand bits above that position, and a 1 at and below it. When the low parts share no set bit, the result is exact. Otherwise the result falls short of the exact sum, and never exceeds it.

The sum is captured in an output register whenever the input valid is high. The valid is delayed by the same one cycle. This makes the block a drop-in stage for signal-processing datapaths that can tolerate small errors.

Top module: `eta_adder`

## Requirements
- R1: The result bits from WIDTH down to SPLIT equal the exact sum of the operand bits from WIDTH-1 down to SPLIT with a carry-in of zero. Bit WIDTH is the carry out of that chain, and the low part never changes it.
- R2: Every low result bit above the most significant low position where both operands are 1 equals the XOR of the two operand bits there.
- R3: At the most significant low position where both operands are 1, and at every lower position, the result bit is 1.
- R4: When the low parts of the operands have no common set bit, the result equals the exact (WIDTH+1)-bit sum.
- R5: The result never exceeds the exact sum of the operands.
- R6: valid_o is low, and sum_o is zero, while rst_ni is low. A result and valid_o appear one clock after valid_i is sampled high, and valid_o is low one clock after valid_i is sampled low.
- R7: While valid_i is low, sum_o keeps its value, whatever the operands do.
- R8: With WIDTH=16 and SPLIT=8, the operands 45978 and 26899 give 72863.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid; loads the output register |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| sum_o | output | WIDTH+1 | Approximate sum |

## Verification
A fault in the carry chain or the control chain shows at the ports in the cycle right after the operands are sampled. A stuck or mis-propagated force-to-one signal gives the wrong low bits only for operands whose low parts overlap at or above the faulty bit, so the stimulus places the first common set bit at the top, middle and bottom of the low part. A carry that leaks across the split shows up as a result above the exact sum, and a sum of two all-ones high parts exercises the carry-out bit.

// File: rtl/eta_pkg.sv
package eta_pkg;
  localparam int unsigned EtaWidthDef = 16;
  localparam int unsigned EtaSplitDef = 8;
endpackage

// File: rtl/eta_rca.sv
module eta_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/eta_ctrl.sv
module eta_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] set_o
);
  // force-to-one flag travels from msb toward lsb
  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == W - 1) begin : g_top
      assign set_o[i] = a_i[i] & b_i[i];
    end else begin : g_mid
      assign set_o[i] = set_o[i+1] | (a_i[i] & b_i[i]);
    end
  end
endmodule

// File: rtl/eta_cfree.sv
module eta_cfree #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] sum_o
);
  for (genvar i = 0; i < W; i++) begin : g_mxor
    assign sum_o[i] = set_i[i] | (a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/eta_adder.sv
module eta_adder #(
  parameter int unsigned WIDTH = eta_pkg::EtaWidthDef,
  parameter int unsigned SPLIT = eta_pkg::EtaSplitDef
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH:0]   sum_o
);
  localparam int unsigned HiW = WIDTH - SPLIT;

  logic [HiW-1:0]   hi_sum;
  logic             hi_cout;
  logic [SPLIT-1:0] set_one;
  logic [SPLIT-1:0] lo_sum;
  logic [WIDTH:0]   sum_d;

  // R1: exact part, carry-in tied low
  eta_rca #(.W(HiW)) u_rca (
    .a_i   (a_i[WIDTH-1:SPLIT]),
    .b_i   (b_i[WIDTH-1:SPLIT]),
    .sum_o (hi_sum),
    .cout_o(hi_cout)
  );

  // R2/R3: carry-free part
  eta_ctrl #(.W(SPLIT)) u_ctrl (
    .a_i  (a_i[SPLIT-1:0]),
    .b_i  (b_i[SPLIT-1:0]),
    .set_o(set_one)
  );

  eta_cfree #(.W(SPLIT)) u_cfree (
    .a_i  (a_i[SPLIT-1:0]),
    .b_i  (b_i[SPLIT-1:0]),
    .set_i(set_one),
    .sum_o(lo_sum)
  );

  assign sum_d = {hi_cout, hi_sum, lo_sum};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sum_o <= sum_d;
    end
  end
endmodule

// File: rtl/eta_adder_chk.sv
module eta_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SPLIT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             valid_o,
  input logic [WIDTH:0]   sum_o
);
  localparam int unsigned HiW = WIDTH - SPLIT;

  logic [WIDTH:0] exact_w;
  logic [HiW:0]   hi_exact;
  logic           lo_overlap;

  assign exact_w    = {1'b0, a_i} + {1'b0, b_i};
  assign hi_exact   = {1'b0, a_i[WIDTH-1:SPLIT]} + {1'b0, b_i[WIDTH-1:SPLIT]};
  assign lo_overlap = |(a_i[SPLIT-1:0] & b_i[SPLIT-1:0]);

  // R6
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R6
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R1
  upper_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sum_o[WIDTH:SPLIT] == $past(hi_exact)));

  // R4
  no_overlap_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !lo_overlap) |=> (sum_o == $past(exact_w)));

  // R5
  never_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sum_o <= $past(exact_w)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o));
endmodule

bind eta_adder eta_adder_chk #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .valid_o(valid_o),
  .sum_o  (sum_o)
);

// File: tb/sim_eta_adder.sv
module sim_eta_adder;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned SPLIT = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [WIDTH-1:0] a_i = '0;
  logic [WIDTH-1:0] b_i = '0;
  logic             valid_o;
  logic [WIDTH:0]   sum_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [WIDTH:0] exp_q[$];
  logic [WIDTH:0] exact_q[$];
  string          tag_q[$];
  logic [WIDTH:0] last_exp = '0;
  bit             done = 1'b0;

  eta_adder #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .sum_o(sum_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic logic [WIDTH:0] ref_sum(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    logic [WIDTH-SPLIT:0] hi;
    logic [SPLIT-1:0]     lo;
    bit                   hit;
    hi  = {1'b0, a[WIDTH-1:SPLIT]} + {1'b0, b[WIDTH-1:SPLIT]};
    hit = 1'b0;
    for (int i = SPLIT - 1; i >= 0; i--) begin
      if (a[i] && b[i]) hit = 1'b1;
      lo[i] = hit ? 1'b1 : (a[i] ^ b[i]);
    end
    return {hi, lo};
  endfunction

  function automatic logic [WIDTH:0] exact_sum(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(string tag, logic [WIDTH:0] act, logic [WIDTH:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [WIDTH:0] exp, string tag);
    @(negedge clk_i);
    a_i = a; b_i = b; valid_i = 1'b1;
    exp_q.push_back(exp);
    exact_q.push_back(exact_sum(a, b));
    tag_q.push_back(tag);
    last_exp = exp;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R6: actual valid 1 expected no result pending");
        end else begin
          logic [WIDTH:0] e, x;
          string t;
          e = exp_q.pop_front();
          x = exact_q.pop_front();
          t = tag_q.pop_front();
          check(t, sum_o, e);
          n_chk++;
          if (sum_o > x) begin
            n_fail++;
            $display("FAIL R5: actual %0d expected at most %0d", sum_o, x);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6 reset state
    check("R6 reset valid", {{WIDTH{1'b0}}, valid_o}, '0);
    check("R6 reset sum", sum_o, '0);
    rst_ni = 1'b1;

    // R8 worked vector
    drive(16'd45978, 16'd26899, 17'd72863, "R8");
    // R4 disjoint low parts, exact
    drive(16'h00F0, 16'h000F, exact_sum(16'h00F0, 16'h000F), "R4");
    drive(16'hFF55, 16'h01AA, exact_sum(16'hFF55, 16'h01AA), "R4 carry-out");
    // R1 upper carry out, lower zero
    drive(16'hFF00, 16'hFF00, 17'h1FE00, "R1");
    // R3 overlap at msb of low part: all low ones, no carry across split
    drive(16'h0080, 16'h0080, 17'h000FF, "R3 top");
    // R2 xor above, ones from bit 4
    drive(16'h0091, 16'h0011, 17'h0009F, "R2");
    // R3 overlap only at bit 0
    drive(16'h12A1, 16'h3441, 17'h046E1, "R3 bottom");
    // R1 low part saturated must not carry into upper
    drive(16'h7FFF, 16'h00FF, 17'h07FFF, "R1 split");
    for (int k = 0; k < 300; k++) begin
      logic [WIDTH-1:0] ra, rb;
      ra = WIDTH'($urandom);
      rb = WIDTH'($urandom);
      drive(ra, rb, ref_sum(ra, rb), "R2 R3 random");
    end

    // R7 hold: operands change with valid low
    @(negedge clk_i);
    valid_i = 1'b0; a_i = 16'hFFFF; b_i = 16'hFFFF;
    @(negedge clk_i);
    check("R6 valid drop", {{WIDTH{1'b0}}, valid_o}, '0);
    a_i = 16'h1234; b_i = 16'h4321;
    repeat (3) @(negedge clk_i);
    check("R7 hold", sum_o, last_exp);
    check("R6 drained", 17'(exp_q.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule